// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU bus and a large external ROM plus an optional external RAM. The CPU cannot write the ROM, so stores into the lower half of the address map (0x0000–0x7FFF) are taken as control writes. Those writes set a RAM enable, a 9-bit ROM bank number kept in two separately written parts, and a 4-bit RAM bank number. The control registers change on the clock edge that samples the write strobe.

The address translation is combinational.
- CPU reads from 0x0000–0x3FFF always see bank 0.
- Reads from 0x4000–0x7FFF see the selected bank, wrapped to the fitted ROM size.
- The 8 KB window at 0xA000–0xBFFF reaches the selected RAM page.
- RAM access is gated. When RAM is disabled or no RAM is fitted, the CPU reads 0xFF and writes never reach the array.

The ROM size is a parameter counting 16 KB banks (2 to 512, any count). The RAM size is a parameter counting 8 KB pages (0 to 16).

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0 and RAM is disabled, so a read of 0x4000 maps to ROM address 0x4000 and a RAM-window read returns 0xFF.
- R2: A write to 0x0000–0x1FFF enables RAM only if the data is exactly 0x0A. Any other value, including 0x8A, disables RAM.
- R3: A write to 0x2000–0x2FFF loads ROM bank bits 7:0 from the data on that clock edge and leaves bank bit 8 unchanged.
- R4: A write to 0x3000–0x3FFF loads ROM bank bit 8 from data bit 0 and leaves bank bits 7:0 unchanged.
- R5: A write to 0x4000–0x5FFF loads the RAM bank from data bits 3:0 and ignores data bits 7:4.
- R6: A write to 0x6000–0x7FFF changes no register: ROM mapping, RAM page and RAM enable all stay as they were.
- R7: A read in 0x0000–0x3FFF maps to ROM address cpu_addr[13:0], whatever the selected bank.
- R8: A read in 0x4000–0x7FFF maps to ROM address (bank mod ROM_BANKS)·16384 + cpu_addr[13:0]. Bank 0 is honoured and is not remapped to bank 1.
- R9: The RAM address is (RAM bank mod RAM_PAGES)·8192 + (cpu_addr − 0xA000).
- R10: A read in 0xA000–0xBFFF returns the RAM array data when RAM is enabled and fitted, and 0xFF otherwise.
- R11: The RAM write strobe is raised only for a CPU write in 0xA000–0xBFFF while RAM is enabled and fitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| rom_addr | output | ROM_AW | Physical ROM address |
| ram_addr | output | RAM_AW | Physical RAM address |
| ram_re | output | 1 | Read enable to the RAM array |
| ram_we | output | 1 | Write enable to the RAM array |
| ram_rdata | input | 8 | Read data from the RAM array |
| cpu_ram_rdata | output | 8 | RAM-window read data returned to the CPU |

## Verification
The bank number is driven with values that separate the two register halves: 0x23, then 0x123 via the high bit, then a low write that must keep bit 8, then a high write with only data bit 0 cleared. With the default count of 96 banks, the expected addresses also exercise the non-power-of-two wrap, including bank 0 in the upper window. The enable key is tried with 0x0A, 0x0B and 0x8A, so an exact compare is told apart from a nibble compare. RAM bank data carrying high-nibble garbage, and a page number above the fitted count, show both masking and wrap. A second instance without RAM shows that the fitted check gates reads and writes independently of the enable.

// File: rtl/cart_bank_pkg.sv
// Shared constants and types for the cartridge bank controller.
// Assumes a 16-bit CPU address map with the control space at 0x0000-0x7FFF.
package cart_bank_pkg;

    localparam logic [7:0] RAM_UNLOCK_KEY = 8'h0A;
    localparam logic [7:0] RAM_IDLE_DATA  = 8'hFF;
    localparam int         ROM_OFS_W      = 14;  // 16 KB bank offset
    localparam int         RAM_OFS_W      = 13;  // 8 KB page offset
    localparam logic [2:0] RAM_WINDOW_TAG = 3'b101;  // 0xA000-0xBFFF

    typedef enum logic [2:0] {
        CTL_NONE,
        CTL_RAM_GATE,
        CTL_BANK_LOW,
        CTL_BANK_TOP,
        CTL_RAM_PAGE,
        CTL_DEAD
    } ctl_kind_e;

    // Classify a control-space write from the top address nibble.
    function automatic ctl_kind_e classify_write(input logic [3:0] top);
        ctl_kind_e k;
        if (top[3])
            k = CTL_NONE;
        else begin
            unique case (top[2:1])
                2'b00: k = CTL_RAM_GATE;
                2'b01: k = top[0] ? CTL_BANK_TOP : CTL_BANK_LOW;
                2'b10: k = CTL_RAM_PAGE;
                default: k = CTL_DEAD;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/cart_ctl_regs.sv
// Control register file: RAM gate, 9-bit ROM bank, 4-bit RAM page.
// Assumes writes are single-cycle strobes sampled on the rising edge.
module cart_ctl_regs
    import cart_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] wr_top,
    input  logic [7:0] wr_data,
    input  logic       wr_en,
    output logic       ram_gate,
    output logic [8:0] rom_bank,
    output logic [3:0] ram_page
);

    ctl_kind_e kind;

    // Decode which register a write targets.
    always_comb kind = wr_en ? classify_write(wr_top) : CTL_NONE;

    // Register updates with synchronous reset to bank 1 / page 0 / gated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_gate <= 1'b0;
            rom_bank <= 9'd1;
            ram_page <= 4'd0;
        end else begin
            unique case (kind)
                CTL_RAM_GATE: ram_gate      <= (wr_data == RAM_UNLOCK_KEY);
                CTL_BANK_LOW: rom_bank[7:0] <= wr_data;
                CTL_BANK_TOP: rom_bank[8]   <= wr_data[0];
                CTL_RAM_PAGE: ram_page      <= wr_data[3:0];
                default: ;
            endcase
        end
    end

    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rom_bank == 9'd1 && ram_page == 4'd0 && !ram_gate)); // R1
    AST_EXACT_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_top[3:1] == 3'b000) |=> (ram_gate == ($past(wr_data) == 8'h0A))); // R2
    AST_LOW_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_top == 4'h2) |=> (rom_bank[8] == $past(rom_bank[8]) &&
                                       rom_bank[7:0] == $past(wr_data))); // R3
    AST_TOP_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_top == 4'h3) |=> (rom_bank[7:0] == $past(rom_bank[7:0]) &&
                                       rom_bank[8] == $past(wr_data[0]))); // R4
    AST_PAGE_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_top[3:1] == 3'b010) |=> (ram_page == $past(wr_data[3:0]))); // R5
    AST_DEAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_top[3:1] == 3'b011) |=> ($stable(rom_bank) && $stable(ram_page) &&
                                              $stable(ram_gate))); // R6

endmodule

// File: rtl/cart_rom_map.sv
// ROM address translation: fixed bank 0 below 0x4000, selected bank above.
// Assumes 2 <= BANKS <= 512; bank numbers wrap modulo BANKS.
module cart_rom_map
    import cart_bank_pkg::*;
#(
    parameter int BANKS  = 96,
    parameter int BANK_W = $clog2(BANKS),
    parameter int AW     = BANK_W + ROM_OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [14:0]   cpu_addr,
    input  logic [8:0]    rom_bank,
    output logic [AW-1:0] rom_addr
);

    localparam bit POW2 = ((BANKS & (BANKS - 1)) == 0);

    logic [BANK_W-1:0] bank_eff;

    generate
        if (POW2) begin : g_mask
            // Power-of-two size: wrap by dropping high bank bits.
            always_comb bank_eff = rom_bank[BANK_W-1:0];
        end else begin : g_mod
            logic [9:0] bank_rem;
            // Other sizes: wrap by a true remainder.
            always_comb begin
                bank_rem = {1'b0, rom_bank} % 10'(BANKS);
                bank_eff = bank_rem[BANK_W-1:0];
            end
        end
    endgenerate

    // Pick bank 0 for the low window, the wrapped bank for the high one.
    always_comb
        rom_addr = {(cpu_addr[14] ? bank_eff : {BANK_W{1'b0}}), cpu_addr[13:0]};

    AST_LOW_WINDOW_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[14] |-> (rom_addr[AW-1:ROM_OFS_W] == '0)); // R7
    AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[14] |-> (int'(rom_addr[AW-1:ROM_OFS_W]) < BANKS)); // R8

endmodule

// File: rtl/cart_ram_map.sv
// RAM window translation and gating for the 0xA000-0xBFFF window.
// Assumes the RAM array returns read data combinationally; PAGES may be 0.
module cart_ram_map
    import cart_bank_pkg::*;
#(
    parameter int PAGES = 4,
    parameter int AW    = RAM_OFS_W + ((PAGES > 1) ? $clog2(PAGES) : 0)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   cpu_addr,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic          ram_gate,
    input  logic [3:0]    ram_page,
    input  logic [7:0]    ram_rdata,
    output logic [AW-1:0] ram_addr,
    output logic          ram_re,
    output logic          ram_we,
    output logic [7:0]    cpu_ram_rdata
);

    localparam bit FITTED = (PAGES > 0);
    localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1;
    localparam bit POW2   = ((PAGES & (PAGES - 1)) == 0);

    logic in_window;
    logic usable;

    // Window hit and access permission.
    always_comb begin
        in_window = (cpu_addr[15:13] == RAM_WINDOW_TAG);
        usable    = FITTED && ram_gate && in_window;
    end

    generate
        if (PAGES <= 1) begin : g_single
            logic unused_page;
            // One page or none: the offset alone addresses the array.
            always_comb begin
                unused_page = ^ram_page;
                ram_addr    = cpu_addr[RAM_OFS_W-1:0];
            end
        end else if (POW2) begin : g_mask
            // Power-of-two page count: wrap by masking.
            always_comb ram_addr = {ram_page[PAGE_W-1:0], cpu_addr[RAM_OFS_W-1:0]};
        end else begin : g_mod
            logic [4:0] page_rem;
            // Other page counts: wrap by remainder.
            always_comb begin
                page_rem = {1'b0, ram_page} % 5'(PAGES);
                ram_addr = {page_rem[PAGE_W-1:0], cpu_addr[RAM_OFS_W-1:0]};
            end
        end
    endgenerate

    // Strobes and read-data substitution.
    always_comb begin
        ram_re        = usable && cpu_rd;
        ram_we        = usable && cpu_wr;
        cpu_ram_rdata = ram_re ? ram_rdata : RAM_IDLE_DATA;
    end

    AST_WE_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_gate && FITTED && cpu_addr[15:13] == 3'b101)); // R11
    AST_IDLE_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !ram_gate) |-> (cpu_ram_rdata == 8'hFF)); // R10

endmodule

// File: rtl/cart_bank_ctrl.sv
// Top of the cartridge bank controller: control registers plus ROM and RAM
// address translation. Assumes a single-cycle CPU strobe per access.
module cart_bank_ctrl
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 96,
    parameter int RAM_PAGES = 4,
    parameter int ROM_AW    = $clog2(ROM_BANKS) + ROM_OFS_W,
    parameter int RAM_AW    = RAM_OFS_W + ((RAM_PAGES > 1) ? $clog2(RAM_PAGES) : 0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_re,
    output logic              ram_we,
    input  logic [7:0]        ram_rdata,
    output logic [7:0]        cpu_ram_rdata
);

    logic       ram_gate;
    logic [8:0] rom_bank;
    logic [3:0] ram_page;

    cart_ctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_top   (cpu_addr[15:12]),
        .wr_data  (cpu_wdata),
        .wr_en    (cpu_wr),
        .ram_gate (ram_gate),
        .rom_bank (rom_bank),
        .ram_page (ram_page)
    );

    cart_rom_map #(.BANKS(ROM_BANKS), .AW(ROM_AW)) u_rom (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr[14:0]),
        .rom_bank (rom_bank),
        .rom_addr (rom_addr)
    );

    cart_ram_map #(.PAGES(RAM_PAGES), .AW(RAM_AW)) u_ram (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_addr      (cpu_addr),
        .cpu_rd        (cpu_rd),
        .cpu_wr        (cpu_wr),
        .ram_gate      (ram_gate),
        .ram_page      (ram_page),
        .ram_rdata     (ram_rdata),
        .ram_addr      (ram_addr),
        .ram_re        (ram_re),
        .ram_we        (ram_we),
        .cpu_ram_rdata (cpu_ram_rdata)
    );

endmodule

// File: tb/cart_bank_ctrl_test.sv
module cart_bank_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  ram_rdata = 8'h5C;

    logic [20:0] rom_addr;
    logic [14:0] ram_addr;
    logic        ram_re, ram_we;
    logic [7:0]  cpu_ram_rdata;

    logic [20:0] n_rom_addr;
    logic [12:0] n_ram_addr;
    logic        n_ram_re, n_ram_we;
    logic [7:0]  n_cpu_ram_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    cart_bank_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_addr(rom_addr), .ram_addr(ram_addr),
        .ram_re(ram_re), .ram_we(ram_we), .ram_rdata(ram_rdata),
        .cpu_ram_rdata(cpu_ram_rdata)
    );

    cart_bank_ctrl #(.RAM_PAGES(0)) uut_noram (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_addr(n_rom_addr), .ram_addr(n_ram_addr),
        .ram_re(n_ram_re), .ram_we(n_ram_we), .ram_rdata(ram_rdata),
        .cpu_ram_rdata(n_cpu_ram_rdata)
    );

    function automatic logic [31:0] rom_exp(input int bank, input logic [15:0] a);
        if (a[14]) return 32'((bank % 96) * 16384 + int'(a[13:0]));
        return 32'(a[13:0]);
    endfunction

    function automatic logic [31:0] ram_exp(input int page, input logic [15:0] a);
        return 32'((page % 4) * 8192 + int'(a - 16'hA000));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1;
    endtask

    task automatic t_reset;
        probe(16'h4000);
        chk("R1 rom bank", 32'(rom_addr), 32'h4000);
        probe(16'hA000);
        chk("R1 ram disabled", 32'(cpu_ram_rdata), 32'hFF);
        chk("R1 ram page", 32'(ram_addr), 32'h0);
        cpu_rd = 1'b0;
    endtask

    task automatic t_enable_key;
        reg_write(16'h0000, 8'h0A);
        probe(16'hA123);
        chk("R2 key 0x0A", 32'(cpu_ram_rdata), 32'h5C);
        chk("R10 enabled read", 32'(ram_re), 32'h1);
        chk("R10 no ram fitted", 32'(n_cpu_ram_rdata), 32'hFF);
        reg_write(16'h1FFF, 8'h0B);
        probe(16'hA123);
        chk("R2 key 0x0B", 32'(cpu_ram_rdata), 32'hFF);
        reg_write(16'h0000, 8'h0A);
        reg_write(16'h1000, 8'h8A);
        probe(16'hB000);
        chk("R2 key 0x8A", 32'(cpu_ram_rdata), 32'hFF);
        cpu_rd = 1'b0;
    endtask

    task automatic t_rom_bank;
        reg_write(16'h2000, 8'h23);
        probe(16'h4567);
        chk("R3 low byte", 32'(rom_addr), rom_exp(9'h023, 16'h4567));
        reg_write(16'h3000, 8'h01);
        probe(16'h4567);
        chk("R4 bit 8 set", 32'(rom_addr), rom_exp(9'h123, 16'h4567));
        reg_write(16'h2FFF, 8'h05);
        probe(16'h7ABC);
        chk("R3 keeps bit 8", 32'(rom_addr), rom_exp(9'h105, 16'h7ABC));
        reg_write(16'h3FFF, 8'hFE);
        probe(16'h4001);
        chk("R4 keeps low", 32'(rom_addr), rom_exp(9'h005, 16'h4001));
        probe(16'h1234);
        chk("R7 low window", 32'(rom_addr), 32'h1234);
        probe(16'h3FFF);
        chk("R7 low window top", 32'(rom_addr), 32'h3FFF);
        reg_write(16'h2000, 8'h00);
        probe(16'h7FFF);
        chk("R8 bank 0 kept", 32'(rom_addr), 32'h3FFF);
        reg_write(16'h2000, 8'hFF);
        reg_write(16'h3000, 8'h01);
        probe(16'h4000);
        chk("R8 wrap 511", 32'(rom_addr), rom_exp(511, 16'h4000));
        cpu_rd = 1'b0;
    endtask

    task automatic t_ram_page;
        reg_write(16'h0000, 8'h0A);
        reg_write(16'h4000, 8'h05);
        probe(16'hBFFF);
        chk("R9 page wrap", 32'(ram_addr), ram_exp(5, 16'hBFFF));
        reg_write(16'h5FFF, 8'hF3);
        probe(16'hA000);
        chk("R5 nibble only", 32'(ram_addr), ram_exp(3, 16'hA000));
        cpu_rd = 1'b0;
    endtask

    task automatic t_dead_writes;
        reg_write(16'h2000, 8'h07);
        reg_write(16'h3000, 8'h00);
        reg_write(16'h4000, 8'h02);
        reg_write(16'h0000, 8'h0A);
        reg_write(16'h6000, 8'hFF);
        reg_write(16'h7FFF, 8'h00);
        probe(16'h4100);
        chk("R6 rom bank held", 32'(rom_addr), rom_exp(7, 16'h4100));
        probe(16'hA010);
        chk("R6 page held", 32'(ram_addr), ram_exp(2, 16'hA010));
        chk("R6 gate held", 32'(cpu_ram_rdata), 32'h5C);
        cpu_rd = 1'b0;
    endtask

    task automatic t_ram_write;
        @(negedge clk);
        cpu_addr = 16'hA010; cpu_wdata = 8'h33; cpu_wr = 1'b1;
        #1;
        chk("R11 enabled write", 32'(ram_we), 32'h1);
        chk("R11 no ram fitted", 32'(n_ram_we), 32'h0);
        @(negedge clk);
        cpu_wr = 1'b0;
        reg_write(16'h0000, 8'h00);
        @(negedge clk);
        cpu_addr = 16'hA010; cpu_wr = 1'b1;
        #1;
        chk("R11 disabled write", 32'(ram_we), 32'h0);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_key();
        t_rom_bank();
        t_ram_page();
        t_dead_writes();
        t_ram_write();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule